// File: doc/BRIEF.md
# Single-precision / bfloat16 bridge with operand classifier

This block connects 32-bit IEEE single-precision bit patterns and 16-bit bfloat16 patterns. A narrowing path turns a single-precision word into bfloat16 and rounds to nearest, ties to even. Patterns whose exponent field is all ones (infinities and NaNs) skip rounding and are cut down by truncation. A widening path turns a bfloat16 word back into single precision by appending zero bits. A classifier looks at the same bfloat16 operand and reports whether it is a NaN, an infinity or a zero.

All three functions are combinational. A parameter places one register stage on every output. The narrowing operand and the bfloat16 operand are separate inputs, so a caller can narrow one value while it widens and classifies another in the same cycle.

Top module: `bf16_xlate`

## Requirements
- R1: When bits [30:23] of `nrw_src` are all ones, `nrw_res` equals bits [31:16] of `nrw_src` unchanged, with no rounding applied.
- R2: Otherwise `nrw_res` is the upper 16 bits of `nrw_src`, rounded to nearest by the lower 16 bits. When those bits are above 0x8000 the result goes up by one. When they are exactly 0x8000 the result goes up only if bit 16 is one (ties to even). Otherwise the result is truncated.
- R3: `wid_res` equals `bf_src` in bits [31:16], with bits [15:0] zero.
- R4: `is_nan` is high exactly when bits [14:7] of `bf_src` are all ones and bits [6:0] are not all zero.
- R5: `is_inf` is high exactly when bits [14:7] of `bf_src` are all ones and bits [6:0] are zero, for either value of the sign bit [15].
- R6: `is_zero` is high exactly when bits [14:0] of `bf_src` are zero, so both 0x0000 and 0x8000 qualify.
- R7: For a finite input (exponent field not all ones), the sign bit [15] of `nrw_res` equals bit 31 of `nrw_src`. Bits [30:0] of the widened result differ from bits [30:0] of the input by at most 0x8000, which keeps the relative error well below 1% for normal values.
- R8: A finite input that rounds past the largest finite bfloat16 gives the infinity pattern of its sign (0x7F80 or 0xFF80). A finite input never gives a NaN pattern.
- R9: With `REG_OUT` = 1, every output shows the result for the inputs present at the previous rising clock edge. While `rst` is high at a clock edge, all outputs are cleared to zero.
- R10: The narrowing result depends only on `nrw_src`, and the widening result and flags depend only on `bf_src`. Each path gives its own correct result when both operands change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| nrw_src | input | 32 | Single-precision pattern to narrow |
| nrw_res | output | 16 | Rounded bfloat16 pattern |
| bf_src | input | 16 | bfloat16 pattern to widen and classify |
| wid_res | output | 32 | Widened single-precision pattern |
| is_nan | output | 1 | `bf_src` is a NaN |
| is_inf | output | 1 | `bf_src` is an infinity of either sign |
| is_zero | output | 1 | `bf_src` is a zero of either sign |

## Verification
Narrowing and the bfloat16 functions (widening and classification) run in the same cycle on independent operands. The bench drives a new pair of operands every cycle: hand-picked rounding ties, exponent-all-ones truncations, overflow into infinity and special classes, followed by a long pseudo-random stream. In every cycle it checks the narrowed word and the widened word and flags against separate models, one cycle after the edge that captured the operands. A path that took the wrong operand or the wrong cycle would show up as a mismatch on that item.

// File: rtl/bf16x_pkg.sv
package bf16x_pkg;

    localparam int F32_W  = 32;
    localparam int BF_W   = 16;
    localparam int EXP_W  = 8;
    localparam int DROP_W = F32_W - BF_W;
    localparam int MAN_W  = BF_W - 1 - EXP_W;
    localparam int FLAG_W = 3;

    typedef struct packed {
        logic               sign;
        logic [EXP_W-1:0]   expo;
        logic [MAN_W-1:0]   man;
    } bf_word_t;

    typedef struct packed {
        logic nan;
        logic inf;
        logic zero;
    } bf_class_t;

    // Bias that rounds the dropped half to nearest, ties to even.
    function automatic logic [F32_W-1:0] round_bias(input logic keep_lsb);
        logic [F32_W-1:0] half_m1;
        half_m1 = {{(BF_W+1){1'b0}}, {(DROP_W-1){1'b1}}};
        return half_m1 + {{(F32_W-1){1'b0}}, keep_lsb};
    endfunction

    function automatic logic exp_all_ones(input logic [F32_W-1:0] w);
        return &w[F32_W-2 -: EXP_W];
    endfunction

endpackage

// File: rtl/bf16x_narrow.sv
module bf16x_narrow
    import bf16x_pkg::*;
(
    input  logic [F32_W-1:0] src,
    output logic [BF_W-1:0]  res
);
    logic             pass_thru;
    logic [F32_W-1:0] biased;

    always_comb begin
        pass_thru = exp_all_ones(src);
        biased    = src + round_bias(src[DROP_W]);
        if (pass_thru)
            res = src[F32_W-1 -: BF_W];
        else
            res = biased[F32_W-1 -: BF_W];
    end
endmodule

// File: rtl/bf16x_widen.sv
module bf16x_widen
    import bf16x_pkg::*;
(
    input  logic [BF_W-1:0]  src,
    output logic [F32_W-1:0] res
);
    assign res = {src, {DROP_W{1'b0}}};
endmodule

// File: rtl/bf16x_classify.sv
module bf16x_classify
    import bf16x_pkg::*;
(
    input  logic [BF_W-1:0] src,
    output bf_class_t       cls
);
    bf_word_t w;
    logic     top_exp;
    logic     frac_any;

    always_comb begin
        w        = src;
        top_exp  = &w.expo;
        frac_any = |w.man;
        cls.nan  = top_exp & frac_any;
        cls.inf  = top_exp & ~frac_any;
        cls.zero = ~(|{w.expo, w.man});
    end
endmodule

// File: rtl/bf16x_stage.sv
module bf16x_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/bf16_xlate.sv
module bf16_xlate
    import bf16x_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [F32_W-1:0]  nrw_src,
    output logic [BF_W-1:0]   nrw_res,
    input  logic [BF_W-1:0]   bf_src,
    output logic [F32_W-1:0]  wid_res,
    output logic              is_nan,
    output logic              is_inf,
    output logic              is_zero
);
    localparam int BUS_W = BF_W + F32_W + FLAG_W;

    logic [BF_W-1:0]  nrw_c;
    logic [F32_W-1:0] wid_c;
    bf_class_t        cls_c;
    bf_class_t        cls_q;
    logic [BUS_W-1:0] bus_d;
    logic [BUS_W-1:0] bus_q;

    bf16x_narrow   u_narrow (.src(nrw_src), .res(nrw_c));
    bf16x_widen    u_widen  (.src(bf_src),  .res(wid_c));
    bf16x_classify u_class  (.src(bf_src),  .cls(cls_c));

    assign bus_d = {nrw_c, wid_c, cls_c};

    bf16x_stage #(.W(BUS_W), .REG(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d   (bus_d),
        .q   (bus_q)
    );

    assign {nrw_res, wid_res, cls_q} = bus_q;
    assign is_nan  = cls_q.nan;
    assign is_inf  = cls_q.inf;
    assign is_zero = cls_q.zero;
endmodule

// File: rtl/bf16x_chk.sv
module bf16x_chk
    import bf16x_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [F32_W-1:0]  nrw_src,
    input logic [BF_W-1:0]   nrw_res,
    input logic [BF_W-1:0]   bf_src,
    input logic [F32_W-1:0]  wid_res,
    input logic              is_nan,
    input logic              is_inf,
    input logic              is_zero
);
    logic [F32_W-1:0] obs_n;
    logic [BF_W-1:0]  obs_b;
    logic             primed;

    generate
        if (REG_OUT) begin : g_dly
            always_ff @(posedge clk) begin
                if (rst) begin
                    primed <= 1'b0;
                    obs_n  <= '0;
                    obs_b  <= '0;
                end else begin
                    primed <= 1'b1;
                    obs_n  <= nrw_src;
                    obs_b  <= bf_src;
                end
            end
        end else begin : g_now
            assign primed = 1'b1;
            assign obs_n  = nrw_src;
            assign obs_b  = bf_src;
        end
    endgenerate

    AST_TRUNC_SPECIAL: assert property (@(posedge clk) disable iff (rst)
        (primed && (&obs_n[30:23])) |-> (nrw_res == obs_n[31:16])); // R1
    AST_ROUND_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (primed && !(&obs_n[30:23])) |->
        ((nrw_res == obs_n[31:16]) || (nrw_res == obs_n[31:16] + 16'd1))); // R2
    AST_WIDE_PLACE: assert property (@(posedge clk) disable iff (rst)
        primed |-> (wid_res == {obs_b, 16'h0000})); // R3
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({is_nan, is_inf, is_zero})); // R4
    AST_ZERO_SIGNLESS: assert property (@(posedge clk) disable iff (rst)
        primed |-> (is_zero == (obs_b[14:0] == 15'h0000))); // R6
    AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (primed && !(&obs_n[30:23])) |-> (nrw_res[15] == obs_n[31])); // R7
    AST_NO_NAN_FROM_FINITE: assert property (@(posedge clk) disable iff (rst)
        (primed && !(&obs_n[30:23]) && (&nrw_res[14:7])) |-> (nrw_res[6:0] == 7'h00)); // R8
endmodule

bind bf16_xlate bf16x_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .nrw_src (nrw_src),
    .nrw_res (nrw_res),
    .bf_src  (bf_src),
    .wid_res (wid_res),
    .is_nan  (is_nan),
    .is_inf  (is_inf),
    .is_zero (is_zero)
);

// File: tb/sim_bf16_xlate.sv
module sim_bf16_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] nrw_src = 32'h0;
    logic [15:0] nrw_res;
    logic [15:0] bf_src = 16'h0;
    logic [31:0] wid_res;
    logic        is_nan, is_inf, is_zero;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] n;
        logic [15:0] b;
        string       tag;
    } item_t;

    item_t sbq[$];

    always #4 clk = ~clk;

    bf16_xlate #(.REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst),
        .nrw_src(nrw_src), .nrw_res(nrw_res),
        .bf_src(bf_src), .wid_res(wid_res),
        .is_nan(is_nan), .is_inf(is_inf), .is_zero(is_zero)
    );

    function automatic logic [15:0] model_narrow(input logic [31:0] x);
        logic [15:0] up;
        logic [15:0] lo;
        up = x[31:16];
        lo = x[15:0];
        if (x[30:23] == 8'hFF) return up;
        if (lo > 16'h8000 || (lo == 16'h8000 && up[0])) return up + 16'd1;
        return up;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] n, input logic [15:0] b, input string tag);
        item_t it;
        @(negedge clk);
        nrw_src = n;
        bf_src  = b;
        it.n = n; it.b = b; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: outputs appear one edge after capture (R9), sampled 2 ns later.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                item_t it;
                logic [15:0] en;
                logic        fin;
                logic        e_ones;
                logic [31:0] rt;
                int          diff;
                it = sbq.pop_front();
                en = model_narrow(it.n);
                check({it.tag, " narrow"}, {16'h0, nrw_res}, {16'h0, en});
                check("R3 widen", wid_res, {it.b, 16'h0000});
                e_ones = (it.b[14:7] == 8'hFF);
                check("R4 nan", {31'h0, is_nan}, {31'h0, e_ones && (it.b[6:0] != 7'h0)});
                check("R5 inf", {31'h0, is_inf}, {31'h0, e_ones && (it.b[6:0] == 7'h0)});
                check("R6 zero", {31'h0, is_zero}, {31'h0, it.b[14:0] == 15'h0});
                fin = (it.n[30:23] != 8'hFF);
                if (fin) begin
                    check("R7 sign", {31'h0, nrw_res[15]}, {31'h0, it.n[31]});
                    rt = {1'b0, nrw_res[14:0], 16'h0000};
                    diff = int'(rt) - int'({1'b0, it.n[30:0]});
                    if (diff < 0) diff = -diff;
                    check("R7 error bound", {31'h0, diff <= 32'h8000}, 32'h1);
                end
            end
        end
    end

    initial begin
        logic [31:0] lf;
        // R9: reset clears outputs even with busy inputs
        nrw_src = 32'h3F818000;
        bf_src  = 16'h7FC0;
        repeat (3) @(posedge clk);
        #2;
        check("R9 reset narrow", {16'h0, nrw_res}, 32'h0);
        check("R9 reset wide", wid_res, 32'h0);
        check("R9 reset flags", {29'h0, is_nan, is_inf, is_zero}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        // first edge out of reset captures the held inputs
        check("R9 first capture", {16'h0, nrw_res}, 32'h00003F82);

        // R9: no change before the capturing edge
        @(negedge clk);
        nrw_src = 32'h40000000;
        #1;
        check("R9 latency hold", {16'h0, nrw_res}, 32'h00003F82);

        // R2 rounding ties and neighbours
        drive(32'h3F808000, 16'h3F80, "R2 tie even down");
        drive(32'h3F818000, 16'h0001, "R2 tie odd up");
        drive(32'h3F808001, 16'h7F7F, "R2 above half");
        drive(32'h3F807FFF, 16'h0000, "R2 below half");
        drive(32'hBF818000, 16'h8000, "R2 negative tie");
        // R1 exponent all ones truncation
        drive(32'h7F80FFFF, 16'h7F80, "R1 inf no round");
        drive(32'hFF81C000, 16'hFF80, "R1 nan no round");
        drive(32'h7FC01234, 16'h7FC0, "R1 qnan");
        drive(32'hFFFFFFFF, 16'hFF81, "R1 all ones");
        // R8 overflow to infinity
        drive(32'h7F7FFFFF, 16'hFFFF, "R8 pos overflow");
        drive(32'hFF7F8000, 16'h7F81, "R8 neg overflow tie");
        // R7 round-trip values
        drive(32'h3F800000, 16'h4049, "R7 one");
        drive(32'hBF800000, 16'hC049, "R7 minus one");
        drive(32'h40000000, 16'h3F00, "R7 two");
        drive(32'hC0000000, 16'h5015, "R7 minus two");
        drive(32'h3F000000, 16'h0080, "R7 half");
        drive(32'hBF000000, 16'h807F, "R7 minus half");
        drive(32'h40490FD0, 16'h1234, "R7 pi");
        drive(32'hC0490FD0, 16'hABCD, "R7 minus pi");
        drive(32'h501502F9, 16'h7FFF, "R7 1e10");
        drive(32'hD01502F9, 16'hFFC0, "R7 minus 1e10");

        // R10: both operands changing every cycle, pseudo-random
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            drive(lf, lf[23:8] ^ lf[15:0], "R10 concurrent");
        end

        repeat (4) @(posedge clk);
        #3;
        check("R10 queue drained", sbq.size(), 32'h0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule